// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers eight synchronous interrupt request lines into a single interrupt signal for a host processor. Each line is captured into a pending register, either on a rising edge or by following its level, and can be blocked by its own mask bit. An in-service register records which lines the processor is currently handling. The interrupt output rises only when an unmasked pending line outranks everything already in service, so nested handling is allowed only for more urgent requests.

Software talks to the block through two port addresses. The high address holds the mask. The low address accepts configuration, vector-base and end-of-interrupt commands. On reads, the low address returns either the pending set or the in-service set. Priority is either fixed, with line 0 most urgent, or rotating, where a line that has just been retired drops to the bottom. When the processor pulses the acknowledge input, the block drives an 8-bit vector on the read data bus, moves the winning line from pending to in-service, and shows the winning line number on a cascade index output. A downstream controller can use that index to select which chained controller supplies the vector.

Top module: `irqc_top`

## Requirements
- R1: After reset the interrupt output is low, the mask reads 0xFF, the pending and in-service sets are empty, edge detection and fixed priority are selected, the low-port read shows the pending set, and the vector base is 0.
- R2: A write to the high port (busAddr=1) loads the mask on the next clock, bit n for line n. A high-port read returns it. A line whose mask bit is 1 never raises the interrupt output.
- R3: In edge mode a 0-to-1 change on a request line sets its pending bit. A line held high after its acknowledge does not become pending again.
- R4: In level mode each pending bit copies its request line's level one clock later, so a line that drops stops being pending.
- R5: In fixed priority, among eligible lines, the lowest-numbered line wins.
- R6: While ackIn is high and the output is asserted, busRdData equals {base[4:0], line[2:0]} and cascIdx equals the winning line. On the following clock that line is set in service and its pending bit is cleared. cascIdx is 0 whenever no acknowledge is being granted.
- R7: The interrupt output is high exactly when the best eligible (pending, unmasked) line ranks strictly above every in-service line.
- R8: A low-port write with bits [7:6]=10 clears the in-service bit of highest current priority, and does nothing when the in-service set is empty.
- R9: A low-port write with bits [7:6]=11 clears the in-service bit named by bits [2:0].
- R10: In rotating mode, an end-of-interrupt that retires line k makes line k+1 (mod 8) the most urgent and line k the least urgent.
- R11: A low-port write with bits [7:6]=00 sets level mode from bit 0, rotating mode from bit 1, and the low-port read source from bit 2 (1 selects the in-service set). A write with bits [7:6]=01 sets the vector base from bits [4:0].
- R12: An acknowledge while the output is low returns {base, 3'b111}, leaves the in-service and pending state unchanged, and keeps cascIdx at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Request lines, synchronous to clk |
| busAddr | input | 1 | Port select: 0 low port, 1 high port |
| busWrEn | input | 1 | Write strobe for one clock |
| busRdEn | input | 1 | Read enable for register reads |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Register read data, or the vector during acknowledge |
| ackIn | input | 1 | Interrupt acknowledge pulse |
| intOut | output | 1 | Interrupt request to the processor |
| cascIdx | output | 3 | Winning line number during a granted acknowledge |

## Verification
The properties assume that an acknowledge pulse and a low-port command never fall in the same clock. The in-service count checks depend on that, because a retire and a grant in one cycle would cancel out. The request lines are taken to be synchronous to clk, and reads and acknowledges last one clock. The stimulus drives every input just after a rising edge and issues at most one bus operation or acknowledge per cycle, including in the random phase.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LINES  = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int DATA_W = 8;
  localparam int BASE_W = DATA_W - IDX_W;
  localparam int CMD_HI = DATA_W - 1;
  localparam int CMD_LO = DATA_W - 2;

  typedef enum logic [1:0] {
    CMD_CFG    = 2'b00,
    CMD_BASE   = 2'b01,
    CMD_EOI_NS = 2'b10,
    CMD_EOI_SP = 2'b11
  } lowCmd_e;

  typedef struct packed {
    logic              maskWr;
    logic [LINES-1:0]  maskVal;
    logic              ackStb;
    logic              eoiNs;
    logic              eoiSp;
    logic [IDX_W-1:0]  eoiLine;
    logic              levelMode;
    logic              rotateEn;
    logic              readIsr;
    logic [BASE_W-1:0] vecBase;
  } strobe_t;

  function automatic logic [IDX_W-1:0] nextLine(input logic [IDX_W-1:0] l);
    return (int'(l) == LINES - 1) ? '0 : IDX_W'(int'(l) + 1);
  endfunction
endpackage

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
(
  input  logic [LINES-1:0] reqVec,
  input  logic [IDX_W-1:0] basePtr,
  output logic             hit,
  output logic [IDX_W-1:0] topLine,
  output logic [IDX_W-1:0] topRank
);
  logic [LINES-1:0] rotVec;

  for (genvar r = 0; r < LINES; r++) begin : g_rot
    assign rotVec[r] = reqVec[IDX_W'((int'(basePtr) + r) % LINES)];
  end

  always_comb begin
    hit     = 1'b0;
    topRank = '0;
    for (int r = LINES - 1; r >= 0; r--) begin
      if (rotVec[r]) begin
        hit     = 1'b1;
        topRank = IDX_W'(r);
      end
    end
    topLine = IDX_W'((int'(basePtr) + int'(topRank)) % LINES);
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              ackIn,
  output strobe_t           stb
);
  logic              cfgLevel;
  logic              cfgRotate;
  logic              cfgReadIsr;
  logic [BASE_W-1:0] baseQ;
  logic              wrLow;
  lowCmd_e           cmd;

  assign wrLow = busWrEn && !busAddr;
  assign cmd   = lowCmd_e'(busWrData[CMD_HI:CMD_LO]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLevel   <= 1'b0;
      cfgRotate  <= 1'b0;
      cfgReadIsr <= 1'b0;
      baseQ      <= '0;
    end else if (wrLow) begin
      if (cmd == CMD_CFG) begin
        cfgLevel   <= busWrData[0];
        cfgRotate  <= busWrData[1];
        cfgReadIsr <= busWrData[2];
      end
      if (cmd == CMD_BASE) begin
        baseQ <= busWrData[BASE_W-1:0];
      end
    end
  end

  always_comb begin
    stb.maskWr    = busWrEn && busAddr;
    stb.maskVal   = busWrData[LINES-1:0];
    stb.ackStb    = ackIn;
    stb.eoiNs     = wrLow && (cmd == CMD_EOI_NS);
    stb.eoiSp     = wrLow && (cmd == CMD_EOI_SP);
    stb.eoiLine   = busWrData[IDX_W-1:0];
    stb.levelMode = cfgLevel;
    stb.rotateEn  = cfgRotate;
    stb.readIsr   = cfgReadIsr;
    stb.vecBase   = baseQ;
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  irqIn,
  input  strobe_t           stb,
  input  logic              busAddr,
  input  logic              busRdEn,
  input  logic              ackIn,
  output logic              intOut,
  output logic [DATA_W-1:0] rdData,
  output logic [IDX_W-1:0]  cascIdx,
  output logic [LINES-1:0]  pendVec,
  output logic [LINES-1:0]  isrVec,
  output logic [LINES-1:0]  maskVec
);
  logic [LINES-1:0] irqPrev;
  logic [LINES-1:0] pendQ;
  logic [LINES-1:0] isrQ;
  logic [LINES-1:0] maskQ;
  logic [IDX_W-1:0] rotPtr;
  logic [IDX_W-1:0] ptrEff;
  logic [LINES-1:0] eligible;
  logic             reqHit;
  logic [IDX_W-1:0] reqLine;
  logic [IDX_W-1:0] reqRank;
  logic             isrHit;
  logic [IDX_W-1:0] isrLine;
  logic [IDX_W-1:0] isrRank;
  logic             ackTake;
  logic [LINES-1:0] winBit;
  logic [LINES-1:0] clrBit;
  logic             eoiDone;
  logic [IDX_W-1:0] eoiLineEff;

  assign ptrEff   = stb.rotateEn ? rotPtr : '0;
  assign eligible = pendQ & ~maskQ;

  irqc_prio u_reqPrio (
    .reqVec (eligible),
    .basePtr(ptrEff),
    .hit    (reqHit),
    .topLine(reqLine),
    .topRank(reqRank)
  );

  irqc_prio u_isrPrio (
    .reqVec (isrQ),
    .basePtr(ptrEff),
    .hit    (isrHit),
    .topLine(isrLine),
    .topRank(isrRank)
  );

  assign intOut  = reqHit && (!isrHit || (reqRank < isrRank));
  assign ackTake = stb.ackStb && intOut;
  assign winBit  = ackTake ? (LINES'(1) << reqLine) : '0;

  always_comb begin
    eoiDone    = 1'b0;
    eoiLineEff = '0;
    if (stb.eoiSp) begin
      eoiDone    = 1'b1;
      eoiLineEff = stb.eoiLine;
    end else if (stb.eoiNs && isrHit) begin
      eoiDone    = 1'b1;
      eoiLineEff = isrLine;
    end
    clrBit = eoiDone ? (LINES'(1) << eoiLineEff) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrev <= '0;
      pendQ   <= '0;
      isrQ    <= '0;
      maskQ   <= '1;
      rotPtr  <= '0;
    end else begin
      irqPrev <= irqIn;
      if (stb.levelMode) begin
        pendQ <= irqIn;
      end else begin
        pendQ <= (pendQ & ~winBit) | (irqIn & ~irqPrev);
      end
      isrQ <= (isrQ & ~clrBit) | winBit;
      if (stb.maskWr) begin
        maskQ <= stb.maskVal;
      end
      if (stb.rotateEn && eoiDone) begin
        rotPtr <= nextLine(eoiLineEff);
      end
    end
  end

  always_comb begin
    if (ackIn) begin
      rdData = {stb.vecBase, (intOut ? reqLine : IDX_W'(LINES - 1))};
    end else if (busRdEn) begin
      if (busAddr) begin
        rdData = DATA_W'(maskQ);
      end else begin
        rdData = DATA_W'(stb.readIsr ? isrQ : pendQ);
      end
    end else begin
      rdData = '0;
    end
  end

  assign cascIdx = (ackIn && intOut) ? reqLine : '0;
  assign pendVec = pendQ;
  assign isrVec  = isrQ;
  assign maskVec = maskQ;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  irqIn,
  input  logic              busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              ackIn,
  output logic              intOut,
  output logic [IDX_W-1:0]  cascIdx
);
  strobe_t          stb;
  logic [LINES-1:0] pendVec;
  logic [LINES-1:0] isrVec;
  logic [LINES-1:0] maskVec;

  irqc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .ackIn    (ackIn),
    .stb      (stb)
  );

  irqc_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .stb    (stb),
    .busAddr(busAddr),
    .busRdEn(busRdEn),
    .ackIn  (ackIn),
    .intOut (intOut),
    .rdData (busRdData),
    .cascIdx(cascIdx),
    .pendVec(pendVec),
    .isrVec (isrVec),
    .maskVec(maskVec)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              ackIn,
  input logic              intOut,
  input logic [IDX_W-1:0]  cascIdx,
  input logic [LINES-1:0]  pendVec,
  input logic [LINES-1:0]  isrVec,
  input logic [LINES-1:0]  maskVec
);
  logic lowCmdWr;
  logic eoiNsWr;
  assign lowCmdWr = busWrEn && !busAddr;
  assign eoiNsWr  = lowCmdWr && (busWrData[CMD_HI:CMD_LO] == 2'b10);

  // R2: a raised output always has an unmasked pending line behind it
  p_unmasked_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((pendVec & ~maskVec) != '0));

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr) |=> (maskVec == $past(busWrData[LINES-1:0])));

  p_ack_marks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && intOut && !busWrEn) |=> ($countones(isrVec) == $countones($past(isrVec)) + 1));

  p_ack_vector_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && intOut) |-> (busRdData[IDX_W-1:0] == cascIdx));

  p_cascade_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ackIn) |-> (cascIdx == '0));

  p_eoi_retires_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    (eoiNsWr && !ackIn && (isrVec != '0)) |=> ($countones(isrVec) + 1 == $countones($past(isrVec))));

  p_spurious_ack_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !intOut && !busWrEn) |=> $stable(isrVec));

  p_spurious_vector_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !intOut) |-> (busRdData[IDX_W-1:0] == '1));
endmodule

bind irqc_top irqc_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .ackIn    (ackIn),
  .intOut   (intOut),
  .cascIdx  (cascIdx),
  .pendVec  (pendVec),
  .isrVec   (isrVec),
  .maskVec  (maskVec)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       busAddr = 1'b0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       ackIn = 1'b0;
  logic       intOut;
  logic [2:0] cascIdx;

  always #10 clk = ~clk;

  irqc_top dut (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .ackIn    (ackIn),
    .intOut   (intOut),
    .cascIdx  (cascIdx)
  );

  // behavioural reference state
  bit [7:0] mPend = 0, mIsr = 0, mMask = 8'hFF, mPrev = 0;
  bit       mLevel = 0, mRot = 0, mSel = 0;
  bit [4:0] mBase = 0;
  int       mPtr = 0;

  int    checks = 0;
  int    fails = 0;
  string curReq = "R1";
  bit    started = 0;
  bit    done = 0;

  function automatic int effPtr();
    return mRot ? mPtr : 0;
  endfunction

  function automatic int topOf(bit [7:0] v);
    for (int r = 0; r < 8; r++) begin
      int l;
      l = (effPtr() + r) % 8;
      if (v[l]) return l;
    end
    return -1;
  endfunction

  function automatic int rankOf(int l);
    return (l - effPtr() + 8) % 8;
  endfunction

  function automatic bit expInt();
    int w;
    int s;
    w = topOf(mPend & ~mMask);
    s = topOf(mIsr);
    if (w < 0) return 1'b0;
    if (s < 0) return 1'b1;
    return rankOf(w) < rankOf(s);
  endfunction

  always @(posedge clk) begin
    bit [7:0] win;
    bit [7:0] clr;
    bit       nLevel, nRot, nSel;
    bit [4:0] nBase;
    int       w, s, l;
    if (!rstN) begin
      mPend = 0; mIsr = 0; mMask = 8'hFF; mPrev = 0;
      mLevel = 0; mRot = 0; mSel = 0; mBase = 0; mPtr = 0;
    end else begin
      win = 0; clr = 0;
      nLevel = mLevel; nRot = mRot; nSel = mSel; nBase = mBase;
      w = topOf(mPend & ~mMask);
      if (ackIn && expInt()) win[w] = 1'b1;
      if (busWrEn && !busAddr) begin
        case (busWrData[7:6])
          2'b00: begin nLevel = busWrData[0]; nRot = busWrData[1]; nSel = busWrData[2]; end
          2'b01: nBase = busWrData[4:0];
          2'b10: begin
            s = topOf(mIsr);
            if (s >= 0) begin
              clr[s] = 1'b1;
              if (mRot) mPtr = (s + 1) % 8;
            end
          end
          default: begin
            l = int'(busWrData[2:0]);
            clr[l] = 1'b1;
            if (mRot) mPtr = (l + 1) % 8;
          end
        endcase
      end
      if (mLevel) mPend = irqIn;
      else mPend = (mPend & ~win) | (irqIn & ~mPrev);
      mIsr = (mIsr & ~clr) | win;
      if (busWrEn && busAddr) mMask = busWrData;
      mPrev = irqIn;
      mLevel = nLevel; mRot = nRot; mSel = nSel; mBase = nBase;
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit       eInt;
    int       w;
    bit [7:0] eRd;
    int       eCasc;
    if (started && rstN && !done) begin
      eInt = expInt();
      w = topOf(mPend & ~mMask);
      eCasc = (ackIn && eInt) ? w : 0;
      if (ackIn) eRd = {mBase, (eInt ? w[2:0] : 3'd7)};
      else if (busRdEn) eRd = busAddr ? mMask : (mSel ? mIsr : mPend);
      else eRd = 0;
      check("intOut", int'(intOut), int'(eInt));
      check("cascIdx", int'(cascIdx), eCasc);
      check("busRdData", int'(busRdData), int'(eRd));
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wrLow(bit [7:0] d);
    busAddr = 1'b0; busWrData = d; busWrEn = 1'b1;
    step();
    busWrEn = 1'b0;
  endtask

  task automatic wrHigh(bit [7:0] d);
    busAddr = 1'b1; busWrData = d; busWrEn = 1'b1;
    step();
    busWrEn = 1'b0;
  endtask

  task automatic rd(bit a);
    busAddr = a; busRdEn = 1'b1;
    step();
    busRdEn = 1'b0;
  endtask

  task automatic ack();
    ackIn = 1'b1;
    step();
    ackIn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R0 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    started = 1'b1;

    curReq = "R1";          // reset state: mask FF, pending empty
    rd(1'b1); rd(1'b0); idle(1);

    curReq = "R2";          // masked lines stay silent, then unmask line 0
    irqIn = 8'h0F; idle(2); rd(1'b0);
    wrHigh(8'hFE); idle(1); rd(1'b1);

    curReq = "R11";         // vector base 0x15
    wrLow(8'h55);
    curReq = "R6";          // acknowledge line 0
    ack(); idle(1); rd(1'b0);

    curReq = "R7";          // lower lines blocked by line 0 in service
    wrHigh(8'h00); idle(2);

    curReq = "R3";          // held-high line 0 is not pending again
    rd(1'b0);

    curReq = "R8";
    wrLow(8'h80); idle(1); ack(); idle(1);

    curReq = "R7";          // new edge on line 0 preempts line 1
    irqIn = 8'h0E; step(); irqIn = 8'h0F; idle(1); ack(); idle(1);

    curReq = "R11";         // low-port read shows in-service set
    wrLow(8'h04); rd(1'b0);

    curReq = "R8"; wrLow(8'h80); rd(1'b0);
    curReq = "R9"; wrLow(8'hC1); rd(1'b0);

    curReq = "R12";         // spurious acknowledge
    wrHigh(8'hFF); idle(1); ack(); rd(1'b0);

    curReq = "R4";          // level mode
    wrLow(8'h01); wrHigh(8'h00); irqIn = 8'h30; idle(2); rd(1'b0);
    ack(); irqIn = 8'h20; idle(1); rd(1'b0);
    wrLow(8'h80); idle(1); ack(); wrLow(8'h80); idle(1);

    curReq = "R10";         // rotating priority with all lines active
    irqIn = 8'h00; wrLow(8'h80); wrLow(8'h03); irqIn = 8'hFF; idle(1);
    for (int i = 0; i < 10; i++) begin
      ack(); wrLow(8'h80); idle(1);
    end

    curReq = "R5";          // fixed priority, lowest index wins
    wrLow(8'h01); irqIn = 8'hA4; idle(1);
    for (int i = 0; i < 3; i++) begin
      ack(); wrLow(8'h80); idle(1);
    end
    irqIn = 8'h80; idle(1); ack(); wrLow(8'hC7); idle(1);

    curReq = "R7";          // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int op;
      irqIn = 8'($urandom);
      op = int'($urandom % 10);
      case (op)
        0, 1: ack();
        2: wrLow(8'h80);
        3: wrLow(8'hC0 | 8'($urandom % 8));
        4: wrLow(8'($urandom % 8));
        5: wrHigh(8'($urandom) & 8'($urandom));
        6: rd(1'($urandom));
        7: wrLow(8'h40 | 8'($urandom % 32));
        default: step();
      endcase
    end

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule